// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns one bus command into the full sequence of T-states and strobes on a bus that shares its low byte between address and data. A small command port supplies the kind of machine cycle, the address and the write data. The block then runs the T-states and drives the address latch pulse, the read, write, acknowledge and refresh strobes, the memory/port select and two status bits. It returns the captured read byte together with a one-clock done pulse. Decoding and arithmetic live elsewhere; a controller above this block issues one command per machine cycle.

Each T-state takes two clocks, a high half and a low half. This is what lets the read strobe of a plain memory read reach half a state further than the strobe of an opcode fetch. Opcode-class cycles (fetch, halt, interrupt acknowledge) are four states long and put a refresh address out in their last two states. The refresh address comes from an internal counter. Read and write cycles are three states long, and port cycles get one wait state automatically. A halt command repeats dummy fetches on its own, so refresh continues until a new command arrives.

Top module: `bus_seq_top`

## Requirements
- R1: `ale` is high for the whole of T1 of every cycle and for T3 of fetch, halt and acknowledge cycles, and is low at all other times. During T1, `ad_oe`=1 and `ad_out` carries the low address byte.
- R2: In T3 and T4 of fetch, halt and acknowledge cycles, `rfsh_n` is low, `ad_oe`=1 and `addr_hi` equals `ivec`. In every other state `rfsh_n` is high.
- R3: `ad_out` shows the refresh count during the refresh window. The count is 0 after reset, rises by one at the end of every fetch, halt and acknowledge cycle, and wraps from 255 to 0.
- R4: `wait_n` is sampled at the middle of T2 and at the middle of each wait state. Each low sample adds one two-clock wait state before T3. In an internal-operation cycle, `wait_n` has no effect on cycle length.
- R5: Port read and port write cycles always contain one wait state, even with `wait_n` held high. External waits are added after that one.
- R6: `rd_n` is low during T2 and all wait states of fetch, halt, memory-read and port-read cycles. For a memory read it also stays low through the first half of T3. `rd_data` takes `ad_in` as sampled on the last clock of the strobe. An acknowledge cycle uses `inta_n` in place of `rd_n` and captures the same way. Write and internal cycles leave `rd_data` unchanged.
- R7: In port cycles, `addr_hi` equals the port address (the low byte of `cmd_addr`) in every state of the cycle.
- R8: The status bits (`stat0`,`stat1`) are: fetch 1,1; memory read 0,1; memory write 1,0; port read 0,1; port write 1,0; halt 0,0; internal 0,1; acknowledge 1,1. `io_m` is 1 only in port cycles. The kind codes on `cmd_kind` are 0 fetch, 1 memory read, 2 memory write, 3 port read, 4 port write, 5 halt, 6 acknowledge, 7 internal.
- R9: When a halt cycle ends and no command is pending, another halt cycle to the same address starts at once. A command presented in the final half-state ends the repetition.
- R10: In write cycles, `wr_n` is low from the second half of T2, through all wait states, to the end of the first half of T3. `ad_oe`=1 with `ad_out` = write data from T2 to the end of the cycle. The strobe falls only after the T2 wait sample.
- R11: `cmd_ready` is high when idle and in the second half of the final T-state. That same clock is the only one with `done` high, and a command is taken only then. After reset the block is idle with `ale`=0, all strobes high, `ad_oe`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 3 | Machine-cycle kind code |
| cmd_addr | input | 16 | Cycle address |
| cmd_wdata | input | 8 | Write byte |
| cmd_ready | output | 1 | Command is taken on this clock if valid |
| done | output | 1 | Last clock of the cycle |
| rd_data | output | 8 | Last captured read byte |
| wait_n | input | 1 | Wait request, active low |
| ivec | input | 8 | Interrupt vector byte shown during refresh |
| ad_in | input | 8 | Low bus byte as read |
| ad_out | output | 8 | Low bus byte as driven |
| ad_oe | output | 1 | Low bus drive enable |
| addr_hi | output | 8 | Upper address byte |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| io_m | output | 1 | 1 for port cycle, 0 for memory |
| stat0 | output | 1 | Status bit 0 |
| stat1 | output | 1 | Status bit 1 |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit low byte and therefore an 8-bit refresh counter. That width lets a run of 256 fetches carry the counter through its wrap. Because the upper and low bytes are the same width, the port-address copy and the vector byte can be compared bit for bit. Zero, one and two external waits on each cycle kind reach both sampling points and the stacking of external waits on top of the automatic port wait.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

    typedef enum logic [2:0] {
        K_FETCH    = 3'd0,
        K_MEMRD    = 3'd1,
        K_MEMWR    = 3'd2,
        K_IORD     = 3'd3,
        K_IOWR     = 3'd4,
        K_HALT     = 3'd5,
        K_INTACK   = 3'd6,
        K_INTERNAL = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_T4
    } tstate_e;

    // four-state cycles that carry a refresh window
    function automatic logic kind_m1(cyc_kind_e k);
        return (k == K_FETCH) || (k == K_HALT) || (k == K_INTACK);
    endfunction

    function automatic logic kind_io(cyc_kind_e k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic kind_wr(cyc_kind_e k);
        return (k == K_MEMWR) || (k == K_IOWR);
    endfunction

    // cycles that pulse the read strobe
    function automatic logic kind_rd(cyc_kind_e k);
        return (k == K_FETCH) || (k == K_MEMRD) || (k == K_IORD) || (k == K_HALT);
    endfunction

    // cycles that capture the low byte
    function automatic logic kind_takes(cyc_kind_e k);
        return kind_rd(k) || (k == K_INTACK);
    endfunction

    function automatic logic kind_waits(cyc_kind_e k);
        return k != K_INTERNAL;
    endfunction

    // returns {bit0, bit1}
    function automatic logic [1:0] kind_status(cyc_kind_e k);
        case (k)
            K_FETCH, K_INTACK: return 2'b11;
            K_MEMWR, K_IOWR:   return 2'b10;
            K_HALT:            return 2'b00;
            default:           return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/bus_seq_timing.sv
module bus_seq_timing
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_kind,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          wait_n,
    input  logic [DW-1:0] ad_in,
    output tstate_e       tst,
    output logic          ph,
    output cyc_kind_e     kind,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rfsh_cnt,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          ready
);

    typedef struct packed {
        tstate_e       tst;
        logic          ph;
        cyc_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          ext_wait;
        logic [DW-1:0] rcnt;
        logic [DW-1:0] rdata;
    } seq_s;

    seq_s seq_d, seq_q;
    logic last_t, strobe_end;

    always_comb begin
        seq_d  = seq_q;
        last_t = (seq_q.tst == TS_T4) ||
                 (seq_q.tst == TS_T3 && !kind_m1(seq_q.kind));
        done   = last_t && seq_q.ph;
        ready  = (seq_q.tst == TS_IDLE) || done;

        // last clock of the read or acknowledge strobe
        strobe_end = (seq_q.kind == K_MEMRD) ?
                     (seq_q.tst == TS_T3 && !seq_q.ph) :
                     (seq_q.ph && !seq_q.ext_wait &&
                      (seq_q.tst == TS_T2 || seq_q.tst == TS_TW));
        if (seq_q.tst != TS_IDLE && kind_takes(seq_q.kind) && strobe_end)
            seq_d.rdata = ad_in;

        if (seq_q.tst != TS_IDLE)
            seq_d.ph = ~seq_q.ph;

        // mid-state wait sample in T2 and in each wait state
        if (!seq_q.ph && (seq_q.tst == TS_T2 || seq_q.tst == TS_TW))
            seq_d.ext_wait = kind_waits(seq_q.kind) &&
                             (!wait_n || (kind_io(seq_q.kind) && seq_q.tst == TS_T2));

        if (seq_q.ph) begin
            case (seq_q.tst)
                TS_T1:        seq_d.tst = TS_T2;
                TS_T2, TS_TW: seq_d.tst = seq_q.ext_wait ? TS_TW : TS_T3;
                TS_T3:        if (kind_m1(seq_q.kind)) seq_d.tst = TS_T4;
                default:      ;
            endcase
        end

        if (done) begin
            if (kind_m1(seq_q.kind))
                seq_d.rcnt = seq_q.rcnt + 1'b1;
            if (!cmd_valid)
                seq_d.tst = (seq_q.kind == K_HALT) ? TS_T1 : TS_IDLE;
        end

        if (ready && cmd_valid) begin
            seq_d.tst   = TS_T1;
            seq_d.ph    = 1'b0;
            seq_d.kind  = cyc_kind_e'(cmd_kind);
            seq_d.addr  = cmd_addr;
            seq_d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{tst: TS_IDLE, ph: 1'b0, kind: K_INTERNAL, addr: '0,
                       wdata: '0, ext_wait: 1'b0, rcnt: '0, rdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tst      = seq_q.tst;
    assign ph       = seq_q.ph;
    assign kind     = seq_q.kind;
    assign addr     = seq_q.addr;
    assign wdata    = seq_q.wdata;
    assign rfsh_cnt = seq_q.rcnt;
    assign rd_data  = seq_q.rdata;

    AST_RFSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_m1(seq_q.kind)) |=> (seq_q.rcnt == DW'($past(seq_q.rcnt) + 1'b1))); // R3

    AST_NO_WAIT_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.tst == TS_T2 && seq_q.ph && seq_q.kind == K_INTERNAL) |=> (seq_q.tst == TS_T3)); // R4

    AST_IO_AUTO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.tst == TS_T2 && seq_q.ph && kind_io(seq_q.kind)) |=> (seq_q.tst == TS_TW)); // R5

    AST_HALT_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seq_q.kind == K_HALT && !cmd_valid) |=> (seq_q.tst == TS_T1 && seq_q.kind == K_HALT)); // R9

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  tstate_e          tst,
    input  logic             ph,
    input  cyc_kind_e        kind,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rfsh_cnt,
    input  logic [AW-DW-1:0] ivec,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             rfsh_n,
    output logic             io_m,
    output logic             stat0,
    output logic             stat1
);

    localparam int HW = AW - DW;

    logic active, m1, win, rfsh_win;
    logic [1:0] st;

    always_comb begin
        active   = (tst != TS_IDLE);
        m1       = kind_m1(kind);
        win      = (tst == TS_T2) || (tst == TS_TW);
        rfsh_win = m1 && (tst == TS_T3 || tst == TS_T4);

        ale    = (tst == TS_T1) || (m1 && tst == TS_T3);
        rd_n   = !(kind_rd(kind) && (win || (kind == K_MEMRD && tst == TS_T3 && !ph)));
        inta_n = !(kind == K_INTACK && win);
        wr_n   = !(kind_wr(kind) &&
                   ((tst == TS_T2 && ph) || tst == TS_TW || (tst == TS_T3 && !ph)));
        rfsh_n = !rfsh_win;

        ad_oe  = 1'b0;
        ad_out = '0;
        if (tst == TS_T1) begin
            ad_oe  = 1'b1;
            ad_out = addr[DW-1:0];
        end else if (rfsh_win) begin
            ad_oe  = 1'b1;
            ad_out = rfsh_cnt;
        end else if (active && kind_wr(kind)) begin
            ad_oe  = 1'b1;
            ad_out = wdata;
        end

        if (rfsh_win)
            addr_hi = ivec;
        else if (kind_io(kind))
            addr_hi = HW'(addr[DW-1:0]);
        else
            addr_hi = addr[AW-1:DW];

        st    = active ? kind_status(kind) : kind_status(K_INTERNAL);
        stat0 = st[1];
        stat1 = st[0];
        io_m  = active && kind_io(kind);
    end

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
    import bus_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_kind,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_wdata,
    output logic             cmd_ready,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    input  logic             wait_n,
    input  logic [AW-DW-1:0] ivec,
    input  logic [DW-1:0]    ad_in,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic [AW-DW-1:0] addr_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             inta_n,
    output logic             rfsh_n,
    output logic             io_m,
    output logic             stat0,
    output logic             stat1
);

    tstate_e       tst;
    logic          ph;
    cyc_kind_e     kind;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rfsh_cnt;

    bus_seq_timing #(.AW(AW), .DW(DW)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .wait_n    (wait_n),
        .ad_in     (ad_in),
        .tst       (tst),
        .ph        (ph),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rfsh_cnt  (rfsh_cnt),
        .rd_data   (rd_data),
        .done      (done),
        .ready     (cmd_ready)
    );

    bus_seq_drive #(.AW(AW), .DW(DW)) u_drive (
        .tst      (tst),
        .ph       (ph),
        .kind     (kind),
        .addr     (addr),
        .wdata    (wdata),
        .rfsh_cnt (rfsh_cnt),
        .ivec     (ivec),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .addr_hi  (addr_hi),
        .ale      (ale),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .inta_n   (inta_n),
        .rfsh_n   (rfsh_n),
        .io_m     (io_m),
        .stat0    (stat0),
        .stat1    (stat1)
    );

    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n)); // R1

    AST_RFSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (rd_n && wr_n && inta_n && ad_oe)); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R10

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R11

endmodule

// File: tb/tb_bus_seq_top.sv
`timescale 1ns/1ps
module tb_bus_seq_top;

    localparam int KF = 0, KMR = 1, KMW = 2, KIR = 3, KIW = 4, KH = 5, KIA = 6, KIN = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = '0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_ready, done;
    logic [7:0]  rd_data;
    logic        wait_n = 1'b1;
    logic [7:0]  ivec = 8'hC3;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ale, rd_n, wr_n, inta_n, rfsh_n, io_m, stat0, stat1;

    always #5 clk = ~clk;

    bus_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .done(done), .rd_data(rd_data), .wait_n(wait_n), .ivec(ivec),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rfsh_n(rfsh_n),
        .io_m(io_m), .stat0(stat0), .stat1(stat1)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int clk_cnt = 0;
    bit finished = 1'b0;

    always @(posedge clk) clk_cnt <= clk_cnt + 1;

    typedef struct {
        int         start;
        int         len;
        logic [7:0] rd;
        string      req;
    } item_t;
    item_t sbq[$];

    logic [7:0] rd_model = 8'h00;
    logic [7:0] rf_model = 8'h00;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // scoreboard monitor: one item per completed cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sbq.size() == 0) begin
                    chk("R11 unexpected done", 16'd1, 16'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk({it.req, " cycle length"}, 16'(clk_cnt - it.start + 1), 16'(it.len));
                    chk("R6 read capture", {8'h00, rd_data}, {8'h00, it.rd});
                end
            end
        end
    end

    function automatic logic [1:0] exp_status(int k);
        case (k)
            KF, KIA:  return 2'b11;
            KMW, KIW: return 2'b10;
            KH:       return 2'b00;
            default:  return 2'b01;
        endcase
    endfunction

    // run one machine cycle; ends at the negedge of its last clock
    task automatic run(input int kind, input logic [15:0] addr, input logic [7:0] wd,
                       input int nw, input bit issue);
        bit io, m1, wr, rdk, ta;
        int nwe, len, kcap, base_w;
        logic [7:0] dbase, exp_rd;
        io   = (kind == KIR) || (kind == KIW);
        m1   = (kind == KF) || (kind == KH) || (kind == KIA);
        wr   = (kind == KMW) || (kind == KIW);
        rdk  = (kind == KF) || (kind == KMR) || (kind == KIR) || (kind == KH);
        ta   = rdk || (kind == KIA);
        nwe  = (kind == KIN) ? 0 : nw + (io ? 1 : 0);
        len  = (m1 ? 8 : 6) + 2 * nwe;
        kcap = ((kind == KMR) ? 4 : 3) + 2 * nwe;
        base_w = io ? 4 : 2;
        dbase = addr[7:0] ^ 8'h3C;
        exp_rd = ta ? (dbase ^ 8'(kcap)) : rd_model;
        rd_model = exp_rd;

        if (issue) begin
            while (!cmd_ready) @(negedge clk);
            cmd_valid = 1'b1;
            cmd_kind  = 3'(kind);
            cmd_addr  = addr;
            cmd_wdata = wd;
        end
        sbq.push_back('{start: clk_cnt + 1, len: len, rd: exp_rd,
                        req: io ? "R5" : ((nw > 0) ? "R4" : "R11")});

        for (int k = 0; k < len; k++) begin
            int ts;
            bit ph, e_ale, e_rd, e_inta, e_wr, e_rf, e_oe, win;
            logic [7:0] e_ad, e_hi;
            @(negedge clk);
            if (k == 0) cmd_valid = 1'b0;
            ad_in  = dbase ^ 8'(k);
            wait_n = !(nw > 0 && k >= base_w && k <= base_w + 2 * nw - 2);
            // T-state: 1=T1 2=T2 3=Tw 4=T3 5=T4
            if (k < 2) ts = 1;
            else if (k < 4) ts = 2;
            else if (k < 4 + 2 * nwe) ts = 3;
            else if (k < 6 + 2 * nwe) ts = 4;
            else ts = 5;
            ph     = k[0];
            win    = (ts == 2) || (ts == 3);
            e_ale  = (ts == 1) || (m1 && ts == 4);
            e_rf   = m1 && (ts >= 4);
            e_rd   = rdk && (win || (kind == KMR && ts == 4 && !ph));
            e_inta = (kind == KIA) && win;
            e_wr   = wr && ((ts == 2 && ph) || ts == 3 || (ts == 4 && !ph));
            e_oe   = (ts == 1) || e_rf || (wr && ts > 1);
            e_ad   = (ts == 1) ? addr[7:0] : (e_rf ? rf_model : wd);
            e_hi   = e_rf ? ivec : (io ? addr[7:0] : addr[15:8]);

            chk("R1 ale", {15'd0, ale}, {15'd0, e_ale});
            chk("R2 rfsh strobe", {15'd0, rfsh_n}, {15'd0, !e_rf});
            chk("R6 read strobe", {14'd0, rd_n, inta_n}, {14'd0, !e_rd, !e_inta});
            chk("R10 write strobe", {15'd0, wr_n}, {15'd0, !e_wr});
            chk("R10 bus enable", {15'd0, ad_oe}, {15'd0, e_oe});
            if (e_oe)
                chk(e_rf ? "R3 refresh value" : (ts == 1 ? "R1 low address" : "R10 write data"),
                    {8'h00, ad_out}, {8'h00, e_ad});
            chk(io ? "R7 port copy" : (e_rf ? "R2 vector byte" : "R1 upper address"),
                {8'h00, addr_hi}, {8'h00, e_hi});
            chk("R8 status", {13'd0, stat0, stat1, io_m}, {13'd0, exp_status(kind), io});
            chk("R11 ready/done", {14'd0, cmd_ready, done},
                {14'd0, k == len - 1, k == len - 1});
        end
        wait_n = 1'b1;
        if (m1) rf_model = rf_model + 8'd1;
    endtask

    task automatic check_idle();
        chk("R11 idle ale", {15'd0, ale}, 16'd0);
        chk("R11 idle strobes", {12'd0, rd_n, wr_n, inta_n, rfsh_n}, 16'hF);
        chk("R11 idle bus", {15'd0, ad_oe}, 16'd0);
        chk("R11 idle ready/done", {14'd0, cmd_ready, done}, 16'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle();                               // R11 reset state
        rst_n = 1'b1;
        @(negedge clk);
        check_idle();

        run(KF,  16'h1234, 8'h00, 0, 1'b1);         // R1 R2 R3 fetch
        run(KF,  16'h2001, 8'h00, 2, 1'b1);         // R4 waits in fetch
        run(KMR, 16'h4567, 8'h00, 0, 1'b1);         // R6 widened read
        run(KMR, 16'h89AB, 8'h00, 1, 1'b1);         // R6 with wait
        run(KMW, 16'hBEEF, 8'hA5, 0, 1'b1);         // R10
        run(KMW, 16'h0F0E, 8'h5A, 2, 1'b1);         // R10 with waits
        run(KIR, 16'h5A7F, 8'h00, 0, 1'b1);         // R5 R7
        run(KIR, 16'h1181, 8'h00, 2, 1'b1);         // R5 plus external
        run(KIW, 16'hEE42, 8'h99, 1, 1'b1);         // R5 R7 R10
        run(KIN, 16'h3333, 8'h00, 2, 1'b1);         // R4 ignored wait
        run(KIA, 16'h0038, 8'h00, 1, 1'b1);         // R6 acknowledge
        run(KMW, 16'h7777, 8'h11, 0, 1'b1);
        @(negedge clk);
        check_idle();                               // R11 back to idle
        run(KH,  16'h0101, 8'h00, 0, 1'b1);         // R9 halt
        run(KH,  16'h0101, 8'h00, 0, 1'b0);         // R9 self repeat
        run(KH,  16'h0101, 8'h00, 1, 1'b0);         // R9 repeat with wait
        run(KF,  16'h0102, 8'h00, 0, 1'b1);         // R9 exit by command
        for (int i = 0; i < 256; i++)               // R3 wrap
            run(KF, 16'(16'h6000 + i), 8'h00, 0, 1'b1);
        @(negedge clk);
        check_idle();
        chk("R3 queue drained", 16'(sbq.size()), 16'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule